// File: doc/BRIEF.md
# OR-Combining Status Line Router

This block routes one-bit status and control lines across a chip. It gathers 27 one-bit sources into a fixed source vector: a constant-low source, a constant-high source, eight external digital pins and seventeen internal status lines. It then produces 26 one-bit destination lines. Each destination owns a 27-bit selection mask, and its value is the logical OR of every source whose mask bit is set. A mask may select any number of sources, from none to all of them.

A destination can be tied permanently low or high by selecting only the constant sources. It can follow one pin, or it can raise a combined alarm from several internal states. Masks are loaded through a plain write port. An index picks the destination and a data word carries the new mask. Every destination is registered, so the network adds one clock of latency.

Top module: `state_xbar`

## Requirements
- R1: The source vector is laid out as follows. Bit 0 is constant 0 and bit 1 is constant 1. Bits 2 to 9 carry `ext_pin[0]` to `ext_pin[7]`. Bits 10 to 26 carry `st_in[0]` to `st_in[16]`.
- R2: `st_out[j]` is the OR of (mask j AND source vector), taken from the values present at the previous rising clock edge.
- R3: A destination whose mask is all zero drives 0, whatever the sources are.
- R4: A destination whose mask has bit 1 set drives 1, whatever the other sources are.
- R5: A destination whose mask has only bit 0 set drives 0 at all times.
- R6: When `wr_en` is high at a rising edge, `wr_mask` becomes the mask of destination `wr_idx`. The new mask shows in `st_out` after the following rising edge, not the same one.
- R7: A write with `wr_idx` of 26 or above changes no mask.
- R8: An active-low `rst_n` clears every mask and every output at once, without waiting for a clock edge.
- R9: While `wr_en` is low, all masks hold, whatever `wr_idx` and `wr_mask` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 8 | External digital pin states |
| st_in | input | 17 | Internal status lines |
| wr_en | input | 1 | Mask write strobe |
| wr_idx | input | 5 | Destination index of the write |
| wr_mask | input | 27 | Mask value to store |
| st_out | output | 26 | Registered destination lines |

## Verification
The assertions assume that `wr_en` is never unknown after reset. They also assume that `wr_idx` and `wr_mask` are known whenever `wr_en` is high. The bench meets this by driving every input to a defined value from time zero, and it changes inputs only on falling edges. Reset is asserted and released a short time after a rising edge, which exercises the asynchronous clear of R8 away from the clock. Random writes deliberately draw indices from the full 5-bit range, so out-of-range writes are mixed with valid ones.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Fixed slots of the source vector
    localparam int SLOT_ZERO = 0;
    localparam int SLOT_ONE  = 1;
    localparam int SLOT_EXT0 = 2;

    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/xbar_input_assembler.sv
module xbar_input_assembler
    import xbar_pkg::*;
#(
    parameter int N_EXT = 8,
    parameter int N_INT = 17,
    parameter int N_IN  = SLOT_EXT0 + N_EXT + N_INT
) (
    input  logic [N_EXT-1:0] ext_pin,
    input  logic [N_INT-1:0] st_in,
    output logic [N_IN-1:0]  src_vec
);

    always_comb begin
        src_vec                            = '0;
        src_vec[SLOT_ZERO]                 = 1'b0;
        src_vec[SLOT_ONE]                  = 1'b1;
        src_vec[SLOT_EXT0 +: N_EXT]        = ext_pin;
        src_vec[SLOT_EXT0 + N_EXT +: N_INT] = st_in;
    end

endmodule

// File: rtl/xbar_mask_bank.sv
module xbar_mask_bank #(
    parameter int N_IN  = 27,
    parameter int N_OUT = 26,
    parameter int IDX_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [N_IN-1:0]             wr_mask,
    output logic [N_OUT-1:0][N_IN-1:0]  mask_q
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_lane
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(j));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[j] <= '0;
            end else if (hit) begin
                mask_q[j] <= wr_mask;
            end
        end
    end

endmodule

// File: rtl/xbar_or_lane.sv
module xbar_or_lane #(
    parameter int N_IN = 27
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] mask,
    input  logic [N_IN-1:0] src_vec,
    output logic            q
);

    logic hit_any;
    assign hit_any = |(mask & src_vec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= hit_any;
        end
    end

endmodule

// File: rtl/state_xbar.sv
module state_xbar
    import xbar_pkg::*;
#(
    parameter int N_EXT = 8,
    parameter int N_INT = 17,
    parameter int N_OUT = 26,
    localparam int N_IN  = SLOT_EXT0 + N_EXT + N_INT,
    localparam int IDX_W = idx_width(N_OUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_pin,
    input  logic [N_INT-1:0] st_in,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [N_IN-1:0]  wr_mask,
    output logic [N_OUT-1:0] st_out
);

    logic [N_IN-1:0]            src_vec;
    logic [N_OUT-1:0][N_IN-1:0] mask_q;

    xbar_input_assembler #(
        .N_EXT (N_EXT),
        .N_INT (N_INT),
        .N_IN  (N_IN)
    ) u_asm (
        .ext_pin (ext_pin),
        .st_in   (st_in),
        .src_vec (src_vec)
    );

    xbar_mask_bank #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_mask (wr_mask),
        .mask_q  (mask_q)
    );

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        xbar_or_lane #(
            .N_IN (N_IN)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .mask    (mask_q[j]),
            .src_vec (src_vec),
            .q       (st_out[j])
        );
    end

endmodule

// File: rtl/state_xbar_chk.sv
module state_xbar_chk #(
    parameter int N_IN  = 27,
    parameter int N_OUT = 26,
    parameter int IDX_W = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [IDX_W-1:0]           wr_idx,
    input logic [N_IN-1:0]            wr_mask,
    input logic [N_OUT-1:0]           st_out,
    input logic [N_OUT-1:0][N_IN-1:0] mask_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_OUT - 1);

    // R6
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx <= LAST_IDX)) |=> (mask_q[$past(wr_idx)] == $past(wr_mask)));

    // R7
    oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx > LAST_IDX)) |=> $stable(mask_q));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

    for (genvar j = 0; j < N_OUT; j++) begin : g_lane_chk
        // R3
        zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[j] == '0) |=> !st_out[j]);

        // R4
        force_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q[j][1] |=> st_out[j]);

        // R5
        const_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[j] == N_IN'(1)) |=> !st_out[j]);
    end

endmodule

bind state_xbar state_xbar_chk #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT),
    .IDX_W (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_mask (wr_mask),
    .st_out  (st_out),
    .mask_q  (mask_q)
);

// File: tb/sim_state_xbar.sv
module sim_state_xbar;

    localparam int N_EXT = 8;
    localparam int N_INT = 17;
    localparam int N_OUT = 26;
    localparam int N_IN  = 27;
    localparam int IDX_W = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n   = 1'b0;
    logic [N_EXT-1:0] ext_pin = '0;
    logic [N_INT-1:0] st_in   = '0;
    logic             wr_en   = 1'b0;
    logic [IDX_W-1:0] wr_idx  = '0;
    logic [N_IN-1:0]  wr_mask = '0;
    logic [N_OUT-1:0] st_out;

    int n_cmp = 0;
    int n_bad = 0;

    state_xbar u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_pin (ext_pin),
        .st_in   (st_in),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_mask (wr_mask),
        .st_out  (st_out)
    );

    // Behavioural reference model
    bit [N_IN-1:0]  m_mask [N_OUT];
    bit [N_OUT-1:0] m_exp = '0;
    bit [N_IN-1:0]  m_src;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mask[i]) m_mask[i] = '0;
            m_exp = '0;
        end else begin
            // R1 layout: const0, const1, pins, internal states
            m_src = {st_in, ext_pin, 1'b1, 1'b0};
            for (int j = 0; j < N_OUT; j++) begin
                m_exp[j] = |(m_mask[j] & m_src);
            end
            if (wr_en && (int'(wr_idx) < N_OUT)) m_mask[wr_idx] = wr_mask;
        end
    end

    // R2: per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (st_out !== m_exp) begin
                n_bad++;
                $display("FAIL R2 t=%0t: st_out=%h expected %h", $time, st_out, m_exp);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t: got %h expected %h", req, $time, got, exp);
        end
    endtask

    task automatic do_wr(input int idx, input logic [N_IN-1:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = IDX_W'(idx);
        wr_mask = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rand_src();
        ext_pin = N_EXT'($urandom);
        st_in   = N_INT'($urandom);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (2) @(posedge clk);
        #2;
        chk("R8", 32'(st_out), 32'd0);
        rst_n = 1'b1;

        // R3: all masks zero after reset
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            rand_src();
            @(negedge clk);
            chk("R3", 32'(st_out), 32'd0);
        end

        // R4: bit 1 forces high
        do_wr(5, 27'b10);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            rand_src();
            @(negedge clk);
            chk("R4", 32'(st_out[5]), 32'd1);
        end

        // R5: bit 0 alone keeps low
        do_wr(6, 27'b1);
        for (int k = 0; k < 4; k++) begin
            ext_pin = '1;
            st_in   = '1;
            @(negedge clk);
            chk("R5", 32'(st_out[6]), 32'd0);
        end

        // R1: pin 3 sits at vector bit 5
        do_wr(7, 27'(1) << 5);
        ext_pin = 8'h08;
        st_in   = '0;
        @(negedge clk);
        chk("R1", 32'(st_out[7]), 32'd1);
        ext_pin = 8'hF7;
        st_in   = '1;
        @(negedge clk);
        chk("R1", 32'(st_out[7]), 32'd0);

        // R1: internal line 16 sits at vector bit 26
        do_wr(8, 27'(1) << 26);
        ext_pin = '1;
        st_in   = 17'h10000;
        @(negedge clk);
        chk("R1", 32'(st_out[8]), 32'd1);
        st_in   = 17'h0FFFF;
        @(negedge clk);
        chk("R1", 32'(st_out[8]), 32'd0);

        // R6: write latency
        do_wr(9, 27'b10);
        chk("R6", 32'(st_out[9]), 32'd0);
        @(negedge clk);
        chk("R6", 32'(st_out[9]), 32'd1);

        // R7: out-of-range writes ignored
        for (int j = 0; j < N_OUT; j++) do_wr(j, 27'b10);
        @(negedge clk);
        chk("R7", 32'(st_out), 32'h3FF_FFFF);
        for (int j = N_OUT; j < 32; j++) do_wr(j, 27'd0);
        @(negedge clk);
        chk("R7", 32'(st_out), 32'h3FF_FFFF);

        // R9: idle port holds masks
        wr_en   = 1'b0;
        wr_idx  = 5'd3;
        wr_mask = '0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            wr_idx = 5'(k);
            rand_src();
        end
        @(negedge clk);
        chk("R9", 32'(st_out), 32'h3FF_FFFF);

        // R2: random traffic, model compared every clock
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            rand_src();
            wr_en   = (($urandom % 4) == 0);
            wr_idx  = IDX_W'($urandom);
            wr_mask = ((c % 3) == 0) ? N_IN'($urandom)
                                     : N_IN'($urandom & $urandom & $urandom);
            if (c == 1500) begin
                @(posedge clk);
                #2;
                rst_n = 1'b0;
                #1;
                chk("R8", 32'(st_out), 32'd0);
                @(posedge clk);
                #2;
                rst_n = 1'b1;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end

endmodule